// File: doc/BRIEF.md
# Eight-Bit Timer with Compare Output

This block is an 8-bit up-counter driven by the system clock through a selectable divider. A compare register is checked against the count on every counted tick. In the free-running mode the count wraps from 255 to 0 and latches an overflow flag. In the clear-on-match mode the count returns to zero when it equals the compare value, so the compare value sets the period. In either mode a match latches a compare flag and flips a square-wave output pin.

Software reaches the block through a small register port with four addresses: the count, the compare value, a control word and a flag word. The flags are sticky and are cleared by writing ones. Each flag drives its own interrupt line through an enable bit in the control word. A write to the count register loads a new value and blocks a match for that one cycle. The register data width follows the counter width, which must be at least 8.

Top module: `tmr8_cmp`

## Requirements
- R1: After a synchronous reset all four registers read 0, `cmp_out` is 0, and both interrupt lines are 0.
- R2: Register addresses are: 0 count, 1 compare value, 2 control word, 3 flag word. Reads are combinational from the current register state. A write updates the register at the clock edge where `reg_wr` is high. Control bits 7:6 read as 0, and a flag word read returns overflow in bit 0 and compare in bit 1.
- R3: Control bits 2:0 select the tick rate: 0 = stopped, 1 = every clock, 2 = every 8th, 3 = every 64th, 4 = every 256th, 5 = every 1024th clock, 6 and 7 = stopped. The divider restarts from zero whenever the rate is stopped. With no tick and no count write, the count holds.
- R4: With control bit 3 = 0 (free-running), each tick adds one to the count. A tick at 255 gives 0 and sets the overflow flag.
- R5: A tick while the count equals the compare value sets the compare flag and inverts `cmp_out`, in both modes.
- R6: With control bit 3 = 1 (clear-on-match), a matching tick loads 0 instead of counting, so a compare value N gives a match every N+1 ticks and a `cmp_out` period of 2(N+1) ticks. With compare value 255, the match takes priority and no overflow is flagged.
- R7: In clear-on-match mode, a count above the compare value keeps counting to 255, wraps to 0 and sets the overflow flag.
- R8: Flags stay set until software writes a 1 to their bit at address 3. Writing 0 leaves a flag unchanged. An event in the same cycle as a clear leaves the flag set.
- R9: `irq_ovf` is the overflow flag gated by control bit 4, and `irq_cmp` is the compare flag gated by control bit 5.
- R10: A count write takes effect at that clock edge. In that cycle the tick neither counts nor produces a match.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | CNT_W | Write data |
| reg_rdata | output | CNT_W | Read data for `reg_addr` |
| irq_ovf | output | 1 | Overflow interrupt request |
| irq_cmp | output | 1 | Compare interrupt request |
| cmp_out | output | 1 | Square wave that inverts on each match |

## Verification
The hardest cases to reach are the exact-cycle collisions: a count write landing on the very tick that would match, and a flag clear landing on the tick that wraps the count. The stimulus reaches them by stopping the divider, preloading the count and compare registers, and then restarting at the every-clock rate. From there the collision cycle is a known number of clocks after the restart. The long wrap past a low compare value is reached the same way, by preloading a count above the compare value and running 246 ticks.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;

    localparam int PRE_W = 10;

    typedef enum logic [1:0] {
        A_CNT = 2'd0,
        A_CMP = 2'd1,
        A_CTL = 2'd2,
        A_FLG = 2'd3
    } reg_addr_e;

    typedef enum logic [2:0] {
        CS_OFF   = 3'd0,
        CS_D1    = 3'd1,
        CS_D8    = 3'd2,
        CS_D64   = 3'd3,
        CS_D256  = 3'd4,
        CS_D1024 = 3'd5,
        CS_RSV6  = 3'd6,
        CS_RSV7  = 3'd7
    } clk_sel_e;

    typedef struct packed {
        logic [1:0] spare;
        logic       cmp_ie;
        logic       ovf_ie;
        logic       ctc;
        clk_sel_e   csel;
    } ctl_t;

    typedef struct packed {
        logic cmp;
        logic ovf;
    } tmr_evt_t;

    function automatic logic sel_running(clk_sel_e s);
        return (s == CS_D1) || (s == CS_D8) || (s == CS_D64) ||
               (s == CS_D256) || (s == CS_D1024);
    endfunction

    function automatic logic [PRE_W-1:0] sel_mask(clk_sel_e s);
        logic [PRE_W-1:0] m;
        case (s)
            CS_D8:    m = PRE_W'(10'h007);
            CS_D64:   m = PRE_W'(10'h03F);
            CS_D256:  m = PRE_W'(10'h0FF);
            CS_D1024: m = PRE_W'(10'h3FF);
            default:  m = '0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/tmr8_prescale.sv
module tmr8_prescale
    import tmr8_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  clk_sel_e csel,
    output logic     tick
);
    logic [PRE_W-1:0] pcnt;
    logic [PRE_W-1:0] mask;
    logic             run;

    always_comb begin
        run  = sel_running(csel);
        mask = sel_mask(csel);
        tick = run && ((pcnt & mask) == mask);
    end

    always_ff @(posedge clk) begin
        if (rst || !run) pcnt <= '0;
        else             pcnt <= pcnt + 1'b1;
    end

    // R3: slower rates never tick on two adjacent clocks
    p_tick_spaced_r3: assert property (@(posedge clk) disable iff (rst)
        (tick && csel != CS_D1) |=> (!tick || csel == CS_D1));

endmodule

// File: rtl/tmr8_count.sv
module tmr8_count
    import tmr8_pkg::*;
#(
    parameter int CNT_W = 8
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             ctc_mode,
    input  logic [CNT_W-1:0] cmp_val,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output tmr_evt_t         evt,
    output logic             wave
);
    localparam logic [CNT_W-1:0] TOP = '1;

    logic             hit;
    logic             step;
    logic [CNT_W-1:0] cnt_nx;

    always_comb begin
        hit     = (count == cmp_val);
        step    = tick && !load;
        evt.cmp = step && hit;
        evt.ovf = step && (count == TOP) && !(ctc_mode && hit);
        if (load)                 cnt_nx = load_val;
        else if (!step)           cnt_nx = count;
        else if (ctc_mode && hit) cnt_nx = '0;
        else                      cnt_nx = count + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            wave  <= 1'b0;
        end else begin
            count <= cnt_nx;
            if (evt.cmp) wave <= !wave;
        end
    end

    // R10: a count write lands exactly at the next edge
    p_cnt_load_r10: assert property (@(posedge clk) disable iff (rst)
        load |=> (count == $past(load_val)));
    // R3: with no tick and no write the count holds
    p_idle_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!tick && !load) |=> $stable(count));
    // R5: the output pin only moves after a match
    p_wave_on_match_r5: assert property (@(posedge clk) disable iff (rst)
        (wave != $past(wave)) |-> $past(evt.cmp));
    // R6: clear-on-match mode returns to zero after a matching tick
    p_ctc_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (ctc_mode && step && count == cmp_val) |=> (count == '0));

endmodule

// File: rtl/tmr8_regs.sv
module tmr8_regs
    import tmr8_pkg::*;
#(
    parameter int CNT_W = 8
)(
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       addr,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [CNT_W-1:0] count,
    input  tmr_evt_t         evt,
    output logic             cnt_load,
    output logic [CNT_W-1:0] cmp_val,
    output ctl_t             ctl,
    output logic [CNT_W-1:0] rd_data,
    output logic             irq_ovf,
    output logic             irq_cmp
);
    reg_addr_e sel;
    tmr_evt_t  flg;
    tmr_evt_t  clr;

    always_comb begin
        sel      = reg_addr_e'(addr);
        cnt_load = wr_en && (sel == A_CNT);
        clr.ovf  = wr_en && (sel == A_FLG) && wr_data[0];
        clr.cmp  = wr_en && (sel == A_FLG) && wr_data[1];
        irq_ovf  = flg.ovf && ctl.ovf_ie;
        irq_cmp  = flg.cmp && ctl.cmp_ie;
        case (sel)
            A_CNT:   rd_data = count;
            A_CMP:   rd_data = cmp_val;
            A_CTL:   rd_data = CNT_W'(ctl);
            default: rd_data = CNT_W'(flg);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_val <= '0;
            ctl     <= '0;
            flg     <= '0;
        end else begin
            if (wr_en && sel == A_CMP) cmp_val <= wr_data;
            if (wr_en && sel == A_CTL) ctl <= ctl_t'({2'b00, wr_data[5:0]});
            flg.ovf <= evt.ovf || (flg.ovf && !clr.ovf);
            flg.cmp <= evt.cmp || (flg.cmp && !clr.cmp);
        end
    end

    // R8: an uncleared flag stays set
    p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (flg.ovf && !clr.ovf) |=> flg.ovf);
    p_cmp_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (flg.cmp && !clr.cmp) |=> flg.cmp);

endmodule

// File: rtl/tmr8_cmp.sv
module tmr8_cmp
    import tmr8_pkg::*;
#(
    parameter int CNT_W = 8
)(
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       reg_addr,
    input  logic             reg_wr,
    input  logic [CNT_W-1:0] reg_wdata,
    output logic [CNT_W-1:0] reg_rdata,
    output logic             irq_ovf,
    output logic             irq_cmp,
    output logic             cmp_out
);
    logic             tick;
    logic             cnt_load;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] cmp_val;
    ctl_t             ctl;
    tmr_evt_t         evt;

    tmr8_prescale u_pre (
        .clk  (clk),
        .rst  (rst),
        .csel (ctl.csel),
        .tick (tick)
    );

    tmr8_count #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .ctc_mode (ctl.ctc),
        .cmp_val  (cmp_val),
        .load     (cnt_load),
        .load_val (reg_wdata),
        .count    (count),
        .evt      (evt),
        .wave     (cmp_out)
    );

    tmr8_regs #(.CNT_W(CNT_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .addr     (reg_addr),
        .wr_en    (reg_wr),
        .wr_data  (reg_wdata),
        .count    (count),
        .evt      (evt),
        .cnt_load (cnt_load),
        .cmp_val  (cmp_val),
        .ctl      (ctl),
        .rd_data  (reg_rdata),
        .irq_ovf  (irq_ovf),
        .irq_cmp  (irq_cmp)
    );

endmodule

// File: tb/tmr8_cmp_tb.sv
module tmr8_cmp_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] reg_addr = 2'd0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       irq_ovf, irq_cmp, cmp_out;

    int nchk = 0;
    int nfail = 0;

    always #10 clk = !clk;

    tmr8_cmp dut_i (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_ovf(irq_ovf), .irq_cmp(irq_cmp), .cmp_out(cmp_out)
    );

    // behavioural reference model
    int m_cnt, m_ocr, m_ctl, m_pc;
    bit m_ovf, m_cmpf, m_oc;
    int div, n_cnt;
    bit tk, ev_o, ev_c;

    function automatic int div_of(int s);
        case (s)
            1: return 1;
            2: return 8;
            3: return 64;
            4: return 256;
            5: return 1024;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_ocr = 0; m_ctl = 0; m_pc = 0;
            m_ovf = 0; m_cmpf = 0; m_oc = 0;
        end else begin
            div  = div_of(m_ctl % 8);
            tk   = (div != 0) && ((m_pc % div) == div - 1);
            ev_o = 0; ev_c = 0;
            n_cnt = m_cnt;
            if (reg_wr && reg_addr == 2'd0) n_cnt = reg_wdata;
            else if (tk) begin
                if (m_cnt == m_ocr) ev_c = 1;
                if (((m_ctl / 8) % 2 == 1) && ev_c) n_cnt = 0;
                else if (m_cnt == 255) begin n_cnt = 0; ev_o = 1; end
                else n_cnt = m_cnt + 1;
            end
            if (reg_wr && reg_addr == 2'd3 && reg_wdata[0]) m_ovf = 0;
            if (reg_wr && reg_addr == 2'd3 && reg_wdata[1]) m_cmpf = 0;
            if (ev_o) m_ovf = 1;
            if (ev_c) begin m_cmpf = 1; m_oc = !m_oc; end
            m_pc = (div == 0) ? 0 : (m_pc + 1) % 1024;
            if (reg_wr && reg_addr == 2'd1) m_ocr = reg_wdata;
            if (reg_wr && reg_addr == 2'd2) m_ctl = reg_wdata % 64;
            m_cnt = n_cnt;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int model_rd(int a);
        case (a)
            0: return m_cnt;
            1: return m_ocr;
            2: return m_ctl;
            default: return m_ovf + 2 * m_cmpf;
        endcase
    endfunction

    task automatic cyc(input int a, input bit we, input int d);
        reg_addr  = a[1:0];
        reg_wr    = we;
        reg_wdata = d[7:0];
        @(negedge clk);
        if (!rst) begin
            chk("R2 model rd_data", reg_rdata, model_rd(a));
            chk("R9 model irq_ovf", irq_ovf, int'(m_ovf && (m_ctl & 16) != 0));
            chk("R9 model irq_cmp", irq_cmp, int'(m_cmpf && (m_ctl & 32) != 0));
            chk("R5 model cmp_out", cmp_out, m_oc);
        end
    endtask

    initial begin
        #(20 * 200000);
        nfail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        int tg, maxv;
        bit prev;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            cyc(a, 0, 0);
            chk("R1 reset register", reg_rdata, 0);
        end
        chk("R1 reset pin", cmp_out, 0);
        chk("R1 reset irq", irq_ovf + irq_cmp, 0);
        // R2 readback
        cyc(1, 1, 8'h37); cyc(1, 0, 0);
        chk("R2 compare readback", reg_rdata, 8'h37);
        cyc(2, 1, 8'hC0); cyc(2, 0, 0);
        chk("R2 control spare bits", reg_rdata, 0);
        // R3 divide by 8
        cyc(1, 1, 200);
        cyc(2, 1, 8'h02);
        repeat (16) cyc(0, 0, 0);
        chk("R3 div8 count", reg_rdata, 2);
        cyc(2, 1, 0);
        // R4 normal wrap
        cyc(3, 1, 3); cyc(0, 1, 250); cyc(2, 1, 1);
        repeat (5) cyc(3, 0, 0);
        chk("R4 before wrap", reg_rdata, 0);
        cyc(3, 0, 0);
        chk("R4 overflow flag", reg_rdata, 1);
        // R9 gating
        cyc(2, 1, 8'h10);
        chk("R9 irq_ovf enabled", irq_ovf, 1);
        cyc(2, 1, 8'h00);
        chk("R9 irq_ovf disabled", irq_ovf, 0);
        // R8 write-one-to-clear
        cyc(3, 1, 0);
        chk("R8 zero write ignored", reg_rdata, 1);
        cyc(3, 1, 1);
        chk("R8 clear", reg_rdata, 0);
        cyc(0, 1, 254); cyc(2, 1, 1); cyc(3, 0, 0);
        cyc(3, 1, 1);
        chk("R8 set beats clear", reg_rdata, 1);
        cyc(2, 1, 0);
        // R5 match in normal mode
        cyc(3, 1, 3); cyc(1, 1, 5); cyc(0, 1, 0);
        prev = cmp_out;
        cyc(2, 1, 1);
        repeat (5) cyc(3, 0, 0);
        chk("R5 before match", reg_rdata, 0);
        cyc(3, 0, 0);
        chk("R5 compare flag", reg_rdata, 2);
        chk("R5 pin toggled", cmp_out, int'(!prev));
        cyc(2, 1, 0);
        // R6 clear-on-match period
        cyc(1, 1, 3); cyc(0, 1, 0); cyc(2, 1, 9);
        tg = 0; maxv = 0; prev = cmp_out;
        for (int i = 0; i < 40; i++) begin
            cyc(0, 0, 0);
            if (cmp_out != prev) tg++;
            prev = cmp_out;
            if (reg_rdata > maxv) maxv = reg_rdata;
        end
        chk("R6 toggles in 40 ticks", tg, 10);
        chk("R6 count ceiling", maxv, 3);
        cyc(2, 1, 0);
        // R6 compare at 255
        cyc(3, 1, 3); cyc(1, 1, 255); cyc(0, 1, 250); cyc(2, 1, 9);
        repeat (6) cyc(3, 0, 0);
        chk("R6 match beats overflow", reg_rdata, 2);
        cyc(2, 1, 0);
        // R7 count above compare
        cyc(1, 1, 3); cyc(0, 1, 10); cyc(3, 1, 3); cyc(2, 1, 9);
        repeat (245) cyc(3, 0, 0);
        chk("R7 at 255", reg_rdata, 0);
        cyc(3, 0, 0);
        chk("R7 wrap overflow", reg_rdata, 1);
        cyc(2, 1, 0);
        // R10 write suppresses match
        cyc(3, 1, 3); cyc(1, 1, 4); cyc(0, 1, 0); cyc(2, 1, 8'h21);
        repeat (4) cyc(0, 0, 0);
        chk("R10 setup count", reg_rdata, 4);
        cyc(0, 1, 4);
        chk("R10 match suppressed", irq_cmp, 0);
        chk("R10 value loaded", reg_rdata, 4);
        cyc(0, 0, 0);
        chk("R10 match next cycle", irq_cmp, 1);
        cyc(0, 1, 100);
        chk("R10 load", reg_rdata, 100);
        // R3 divide by 64 and reserved select
        cyc(2, 1, 0); cyc(0, 1, 0); cyc(1, 1, 200); cyc(2, 1, 8'h03);
        repeat (128) cyc(0, 0, 0);
        chk("R3 div64 count", reg_rdata, 2);
        cyc(2, 1, 6);
        repeat (10) cyc(0, 0, 0);
        chk("R3 reserved select stops", reg_rdata, 2);
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule